// File: doc/BRIEF.md
# SDRAM Mode Register Command Handler

This block is the device-side logic of a DDR-style SDRAM that watches the command pins, the clock enable, the address bus and the bank-address bits. It picks out the mode-register-set command and judges whether it may be taken. When the command is legal, it stores the burst length, the burst ordering, the read latency and the test-mode bit. The stored fields are presented in decoded form to the rest of the device model.

Each accepted write opens a short busy window. It also sends a one-cycle pulse that returns the companion extended mode register to its default value. A command that arrives while the block is busy, or while any bank is open, is refused: an error pulse is raised and nothing changes. A command that carries a reserved field code or nonzero bank-address bits is also refused, but it raises a sticky illegal-code flag instead of the error pulse.

All outputs are registered. They change on the clock edge that samples the command.

Top module: `sdr_mode_reg_ctl`

## Requirements
- R1: A mode write is recognised only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all sampled low on one rising edge. If any one of them is high, the edge has no effect on any output.
- R2: A recognised command is silently ignored, with no error pulse and no change to any output, unless `cke` was high on the previous rising edge and is high on the current one.
- R3: If any bit of `bank_open` is set when a command is recognised, the command is refused. `cmd_err` is high for exactly the following cycle, and the stored mode is unchanged.
- R4: The address sampled with the command supplies the fields. Bits 2:0 are the burst-length code. Bit 3 is the burst order (0 = sequential, 1 = interleaved, shown on `burst_interleave`). Bits 6:4 are the latency code. Bit 7 is test mode, shown on `test_mode`.
- R5: A command with `ba` not equal to 0 sets `illegal_code` and leaves the stored mode unchanged.
- R6: Burst-length codes 001, 010 and 011 give `burst_len` values of 2, 4 and 8. Any other code sets `illegal_code` and keeps the previous setting.
- R7: Latency codes 010 and 011 give `cas_lat` values of 2 and 3. Any other code sets `illegal_code` and keeps the previous setting.
- R8: After an accepted write, `busy` is high for two cycles. A recognised command in that window is refused with a `cmd_err` pulse and changes nothing.
- R9: Every accepted write produces a single one-cycle `ext_reset` pulse. Refused or ignored commands produce none.
- R10: After reset, `mode_valid`, `illegal_code`, `busy`, `cmd_err` and `ext_reset` are 0, and `burst_len` and `cas_lat` read 0 until the first accepted write. An accepted write sets `mode_valid` and clears `illegal_code`.
- R11: A refusal for busy or an open bank takes priority over the code check. Such a command leaves `illegal_code` as it was, even if its codes are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (13) | Address bus carrying the mode value |
| ba | input | BA_W (2) | Bank-address bits |
| bank_open | input | NUM_BANKS (4) | One bit per bank, set while that bank is open |
| burst_len | output | 4 | Decoded burst length (2, 4, 8) or 0 before the first write |
| burst_interleave | output | 1 | Stored burst order, 1 = interleaved |
| cas_lat | output | 2 | Decoded read latency (2 or 3) or 0 before the first write |
| test_mode | output | 1 | Stored test-mode bit |
| mode_valid | output | 1 | High once a write has been accepted |
| illegal_code | output | 1 | Last recognised, non-refused command carried a reserved code |
| busy | output | 1 | Write-completion window in progress |
| cmd_err | output | 1 | One-cycle pulse for a command refused for busy or an open bank |
| ext_reset | output | 1 | One-cycle pulse returning the extended register to default |

## Verification
Two functions can fall on the same edge: refusal for busy or an open bank, and the reserved-code check. The bench provokes this by sending a command with a reserved burst-length code while a bank is open, and again on the cycle right after an accepted write.

The result is judged at the ports. `cmd_err` must pulse. `illegal_code` must keep the value it held before the command. The decoded fields must not move.

An accepted write raises the field update, `busy` and `ext_reset` on the same edge. Every cycle's output vector is compared against an independent model.

// File: rtl/sdr_mrs_pkg.sv
package sdr_mrs_pkg;

  // Position of the mode fields inside the sampled address word
  localparam int BL_LSB  = 0;
  localparam int BL_W    = 3;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int CL_W    = 3;
  localparam int TM_BIT  = 7;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [BL_W-1:0] bl_code;
    logic            interleave;
    logic [CL_W-1:0] cl_code;
    logic            test_mode;
  } mode_fields_t;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_REJECT  = 2'd1,
    ACT_BADCODE = 2'd2,
    ACT_WRITE   = 2'd3
  } mrs_action_e;

  function automatic logic bl_code_ok(input logic [BL_W-1:0] c);
    return (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
  endfunction

  // 001 -> 2, 010 -> 4, 011 -> 8
  function automatic logic [3:0] bl_length(input logic [BL_W-1:0] c);
    return 4'd1 << c[1:0];
  endfunction

  function automatic logic cl_code_ok(input logic [CL_W-1:0] c);
    return (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic logic [1:0] cl_cycles(input logic [CL_W-1:0] c);
    return c[1:0];
  endfunction

  function automatic mode_fields_t split_word(input logic [FIELD_W-1:0] a);
    mode_fields_t f;
    f.bl_code    = a[BL_LSB +: BL_W];
    f.interleave = a[BT_BIT];
    f.cl_code    = a[CL_LSB +: CL_W];
    f.test_mode  = a[TM_BIT];
    return f;
  endfunction

endpackage

// File: rtl/sdr_mrs_decode.sv
module sdr_mrs_decode
  import sdr_mrs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [FIELD_W-1:0]   field_word,
  input  logic [BA_W-1:0]      ba,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 busy,
  output mrs_action_e          action,
  output mode_fields_t         fields,
  output logic                 cmd_seen
);

  logic cke_q;
  logic pins_low;
  logic codes_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  assign pins_low = ~cs_n & ~ras_n & ~cas_n & ~we_n;
  assign cmd_seen = pins_low & cke & cke_q;
  assign fields   = split_word(field_word);
  assign codes_ok = (ba == '0) && bl_code_ok(fields.bl_code) && cl_code_ok(fields.cl_code);

  always_comb begin
    if (!cmd_seen)                     action = ACT_NONE;
    else if (busy || (|bank_open))     action = ACT_REJECT;
    else if (!codes_ok)                action = ACT_BADCODE;
    else                               action = ACT_WRITE;
  end

endmodule

// File: rtl/sdr_mrs_busy.sv
module sdr_mrs_busy #(
  parameter int BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CNT_W'(BUSY_CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/sdr_mrs_store.sv
module sdr_mrs_store
  import sdr_mrs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  mrs_action_e  action,
  input  mode_fields_t fields,
  output logic [3:0]   burst_len,
  output logic         burst_interleave,
  output logic [1:0]   cas_lat,
  output logic         test_mode,
  output logic         mode_valid,
  output logic         illegal_code,
  output logic         cmd_err,
  output logic         ext_reset
);

  mode_fields_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held         <= '0;
      mode_valid   <= 1'b0;
      illegal_code <= 1'b0;
      cmd_err      <= 1'b0;
      ext_reset    <= 1'b0;
    end else begin
      cmd_err   <= (action == ACT_REJECT);
      ext_reset <= (action == ACT_WRITE);
      case (action)
        ACT_WRITE: begin
          held         <= fields;
          mode_valid   <= 1'b1;
          illegal_code <= 1'b0;
        end
        ACT_BADCODE: illegal_code <= 1'b1;
        default: ;
      endcase
    end
  end

  assign burst_len        = mode_valid ? bl_length(held.bl_code) : 4'd0;
  assign cas_lat          = mode_valid ? cl_cycles(held.cl_code) : 2'd0;
  assign burst_interleave = held.interleave;
  assign test_mode        = held.test_mode;

endmodule

// File: rtl/sdr_mode_reg_ctl.sv
module sdr_mode_reg_ctl
  import sdr_mrs_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int NUM_BANKS = 4,
  parameter int BUSY_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BA_W-1:0]      ba,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic [3:0]           burst_len,
  output logic                 burst_interleave,
  output logic [1:0]           cas_lat,
  output logic                 test_mode,
  output logic                 mode_valid,
  output logic                 illegal_code,
  output logic                 busy,
  output logic                 cmd_err,
  output logic                 ext_reset
);

  mrs_action_e  action;
  mode_fields_t fields;
  logic         cmd_seen;

  // Named events for the checker
  logic ev_write;
  logic ev_reject;
  logic ev_bad_code;

  logic unused_addr_hi;

  generate
    if (ADDR_W > FIELD_W) begin : g_hi
      assign unused_addr_hi = ^addr[ADDR_W-1:FIELD_W];
    end else begin : g_no_hi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  sdr_mrs_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .field_word (addr[FIELD_W-1:0]),
    .ba         (ba),
    .bank_open  (bank_open),
    .busy       (busy),
    .action     (action),
    .fields     (fields),
    .cmd_seen   (cmd_seen)
  );

  assign ev_write    = (action == ACT_WRITE);
  assign ev_reject   = (action == ACT_REJECT);
  assign ev_bad_code = (action == ACT_BADCODE);

  sdr_mrs_busy #(
    .BUSY_CYC (BUSY_CYC)
  ) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_write),
    .busy  (busy)
  );

  sdr_mrs_store u_store (
    .clk              (clk),
    .rst_n            (rst_n),
    .action           (action),
    .fields           (fields),
    .burst_len        (burst_len),
    .burst_interleave (burst_interleave),
    .cas_lat          (cas_lat),
    .test_mode        (test_mode),
    .mode_valid       (mode_valid),
    .illegal_code     (illegal_code),
    .cmd_err          (cmd_err),
    .ext_reset        (ext_reset)
  );

endmodule

// File: rtl/sdr_mrs_chk.sv
module sdr_mrs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       cke,
  input logic [3:0] burst_len,
  input logic       burst_interleave,
  input logic [1:0] cas_lat,
  input logic       test_mode,
  input logic       mode_valid,
  input logic       illegal_code,
  input logic       busy,
  input logic       cmd_err,
  input logic       ext_reset,
  input logic       ev_write,
  input logic       ev_reject,
  input logic       ev_bad_code
);

  AST_WRITE_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> busy); // R8

  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_write); // R8

  AST_NO_ACCEPT_WITHOUT_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || cs_n) |-> !ev_write); // R2

  AST_REJECT_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> ($stable(burst_len) && $stable(cas_lat) && $stable(burst_interleave)
                   && $stable(test_mode) && $stable(mode_valid))); // R3

  AST_REJECT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> $stable(illegal_code)); // R11

  AST_ERR_FROM_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(ev_reject)); // R3

  AST_BAD_CODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_code |=> (illegal_code && $stable(burst_len) && $stable(cas_lat))); // R5

  AST_EXT_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_reset |-> $past(ev_write)); // R9

  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (burst_len == 4'd2 || burst_len == 4'd4 || burst_len == 4'd8)); // R6

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (cas_lat == 2'd2 || cas_lat == 2'd3)); // R7

  AST_VALID_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(ev_write)); // R10

endmodule

bind sdr_mode_reg_ctl sdr_mrs_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cs_n             (cs_n),
  .cke              (cke),
  .burst_len        (burst_len),
  .burst_interleave (burst_interleave),
  .cas_lat          (cas_lat),
  .test_mode        (test_mode),
  .mode_valid       (mode_valid),
  .illegal_code     (illegal_code),
  .busy             (busy),
  .cmd_err          (cmd_err),
  .ext_reset        (ext_reset),
  .ev_write         (ev_write),
  .ev_reject        (ev_reject),
  .ev_bad_code      (ev_bad_code)
);

// File: tb/sdr_mode_reg_ctl_tb.sv
module sdr_mode_reg_ctl_tb;

  localparam int ADDR_W = 13;
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_MRS  = 4'b0000;
  localparam logic [3:0] C_NEAR = 4'b0001;
  localparam logic [3:0] C_DESL = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0] ba = '0;
  logic [3:0] bank_open = '0;
  logic [3:0] burst_len;
  logic burst_interleave, test_mode, mode_valid, illegal_code, busy, cmd_err, ext_reset;
  logic [1:0] cas_lat;

  always #10 clk = ~clk;

  sdr_mode_reg_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .bank_open(bank_open),
    .burst_len(burst_len), .burst_interleave(burst_interleave), .cas_lat(cas_lat),
    .test_mode(test_mode), .mode_valid(mode_valid), .illegal_code(illegal_code),
    .busy(busy), .cmd_err(cmd_err), .ext_reset(ext_reset)
  );

  typedef struct {
    int          due;
    logic [12:0] vec;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model state
  bit       m_cke_prev = 0;
  int       m_busy = 0;
  bit       m_valid = 0, m_ill = 0, m_bt = 0, m_tm = 0;
  logic [3:0] m_bl = 0;
  logic [1:0] m_cl = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [12:0] out_vec();
    return {busy, cmd_err, ext_reset, mode_valid, illegal_code,
            burst_len, burst_interleave, cas_lat, test_mode};
  endfunction

  task automatic check_vec(input logic [12:0] exp, input string req);
    logic [12:0] got;
    got = out_vec();
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (busy,err,ext,valid,ill,bl,bt,cl,tm)", req, got, exp);
    end
  endtask

  // Monitor: pops expected items as their cycle comes due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      check_vec(it.vec, it.req);
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic cke_i, input logic [3:0] cmd, input logic [7:0] a,
                      input logic [1:0] b, input logic [3:0] banks, input string req);
    bit recog, err, ext, bl_ok, cl_ok;
    logic [3:0] len;
    item_t it;
    @(negedge clk);
    cke = cke_i;
    {cs_n, ras_n, cas_n, we_n} = cmd;
    addr = {5'b0, a};
    ba = b;
    bank_open = banks;
    err = 0;
    ext = 0;
    recog = (cmd == 4'b0000) && cke_i && m_cke_prev;
    case (a[2:0])
      3'd1: len = 4'd2;
      3'd2: len = 4'd4;
      3'd3: len = 4'd8;
      default: len = 4'd0;
    endcase
    bl_ok = (len != 0);
    cl_ok = (a[6:4] == 3'd2) || (a[6:4] == 3'd3);
    if (m_busy > 0) m_busy--;
    if (recog) begin
      if (busy === 1'b1 || banks != 0) err = 1;
      else if (b != 0 || !bl_ok || !cl_ok) m_ill = 1;
      else begin
        ext = 1; m_valid = 1; m_ill = 0;
        m_bl = len; m_cl = a[5:4]; m_bt = a[3]; m_tm = a[7];
        m_busy = 2;
      end
    end
    m_cke_prev = cke_i;
    it.due = cyc + 1;
    it.vec = {m_busy != 0, err, ext, m_valid, m_ill, m_bl, m_bt, m_cl, m_tm};
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, C_NOP, 8'h00, 2'b00, 4'h0, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_vec(13'b0, "R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R10 idle after reset");
    // R1: three of four pins low, and deselected
    step(1'b1, C_NEAR, 8'h21, 2'b00, 4'h0, "R1 we high");
    step(1'b1, C_DESL, 8'h21, 2'b00, 4'h0, "R1 cs high");
    idle(1, "R10 still invalid");
    // R4/R6/R7: BL2 sequential CL2
    step(1'b1, C_MRS, 8'h21, 2'b00, 4'h0, "R4 write bl2 cl2");
    idle(3, "R8 busy window");
    // BL4 interleave CL3 test mode
    step(1'b1, C_MRS, 8'hBA, 2'b00, 4'h0, "R4 write bl4 il cl3 tm");
    idle(3, "R9 single ext pulse");
    step(1'b1, C_MRS, 8'h33, 2'b00, 4'h0, "R6 write bl8");
    // R8: commands during the busy window
    step(1'b1, C_MRS, 8'h22, 2'b00, 4'h0, "R8 refused busy 1");
    step(1'b1, C_MRS, 8'h22, 2'b00, 4'h0, "R8 refused busy 2");
    step(1'b1, C_MRS, 8'h22, 2'b00, 4'h0, "R8 accepted after window");
    idle(3, "R8 idle");
    // R3: open bank
    step(1'b1, C_MRS, 8'h31, 2'b00, 4'h4, "R3 bank open");
    idle(1, "R3 idle");
    // R11: open bank with reserved code
    step(1'b1, C_MRS, 8'h27, 2'b00, 4'h1, "R11 bank open reserved bl");
    idle(1, "R11 flag unchanged");
    // R6: reserved burst-length codes
    step(1'b1, C_MRS, 8'h20, 2'b00, 4'h0, "R6 bl code 000");
    step(1'b1, C_MRS, 8'h24, 2'b00, 4'h0, "R6 bl code 100");
    step(1'b1, C_MRS, 8'h27, 2'b00, 4'h0, "R6 bl code 111");
    step(1'b1, C_MRS, 8'h31, 2'b00, 4'h0, "R10 good write clears flag");
    idle(3, "R10 idle");
    // R7: reserved latency codes
    step(1'b1, C_MRS, 8'h13, 2'b00, 4'h0, "R7 cl code 001");
    step(1'b1, C_MRS, 8'h43, 2'b00, 4'h0, "R7 cl code 100");
    step(1'b1, C_MRS, 8'h72, 2'b00, 4'h0, "R7 cl code 111");
    // R5: nonzero bank address
    step(1'b1, C_MRS, 8'h22, 2'b01, 4'h0, "R5 ba 01");
    step(1'b1, C_MRS, 8'h22, 2'b10, 4'h0, "R5 ba 10");
    step(1'b1, C_MRS, 8'h22, 2'b00, 4'h0, "R9 write after rejects");
    idle(3, "R9 idle");
    // R11: reserved code on the cycle right after a write
    step(1'b1, C_MRS, 8'h21, 2'b00, 4'h0, "R11 write");
    step(1'b1, C_MRS, 8'h26, 2'b00, 4'h0, "R11 busy beats reserved code");
    idle(3, "R11 idle");
    // R2: clock enable
    step(1'b0, C_NOP, 8'h00, 2'b00, 4'h0, "R2 cke low");
    step(1'b1, C_MRS, 8'h33, 2'b00, 4'h0, "R2 cke just raised");
    step(1'b0, C_MRS, 8'h33, 2'b00, 4'h0, "R2 cke low in command");
    idle(2, "R2 idle");
    step(1'b1, C_MRS, 8'h33, 2'b00, 4'h0, "R2 cke held high accepted");
    idle(4, "R8 final idle");
    done = 1;
    finish_run();
  end

endmodule